// File: doc/BRIEF.md
# Variable-Size Region Access Checker

This block is a small per-thread memory map that stands on the fast path of every load, store and instruction fetch. It holds a few entries, each describing one contiguous region of any length by an inclusive lower bound, an inclusive upper bound, a permission set and an enable bit. Every entry has its own pair of magnitude comparators, so all entries are searched in the same cycle and no table walk is needed. A single read-write region can hold a downward-growing stack, a static segment and an upward-growing heap together. A region can be fetch-only, which gives a true split between code and data, or readable but not fetchable.

Software loads entries through a plain write port. Accesses arrive on a valid/ready request stream and leave on a valid/ready response stream through one register stage. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle (`!resp_valid || resp_ready`). While `resp_valid` is high and `resp_ready` is low, the response is frozen and no new request is taken. The response reports whether an enabled entry matched, which entry it was, and whether the access must be refused.

Top module: `region_map_guard`

## Requirements
- R1: After reset `resp_valid` is 0, `req_ready` is 1 and every entry is disabled, so every access faults as a miss.
- R2: An address hits an enabled entry when lower bound <= address <= upper bound, both ends inclusive; an entry whose lower bound exceeds its upper bound never hits.
- R3: An access that hits no enabled entry returns `resp_hit`=0, `resp_idx`=0 and `resp_fault`=1.
- R4: Permission bits are bit0 read, bit1 write, bit2 fetch. Access type codes are 0 read, 1 write, 2 fetch and 3 reserved. A hit faults when the entry lacks the bit for the access type, and type 3 always faults.
- R5: A fetch-only entry (permission 3'b100) lets a fetch pass and faults a read or write. A read-only entry (3'b001) faults a fetch.
- R6: When several enabled entries hold the address, the lowest-numbered one is reported and its permissions decide the fault.
- R7: A request taken at a clock edge has its response on the outputs with `resp_valid`=1 right after that edge. This is one cycle of latency.
- R8: While `resp_valid`=1 and `resp_ready`=0, `req_ready` is 0 and `resp_hit`, `resp_idx` and `resp_fault` hold their values.
- R9: An entry write takes effect at the next clock edge. A request taken at the same edge as the write sees the old entry. A request taken later sees the new one, so clearing the enable bit stops the entry from hitting for every later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry number to write |
| cfg_base | input | ADDR_W | Inclusive lower bound |
| cfg_limit | input | ADDR_W | Inclusive upper bound |
| cfg_perm | input | 3 | Permission set: bit0 read, bit1 write, bit2 fetch |
| cfg_valid | input | 1 | Enable bit of the written entry |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Access address |
| req_type | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_hit | output | 1 | An enabled entry holds the address |
| resp_idx | output | IDX_W | Lowest matching entry, 0 on a miss |
| resp_fault | output | 1 | Access refused |

## Verification
Every response is due exactly one clock edge after its request is taken. The bench therefore drives a request on a falling edge and compares the outputs on the next falling edge, one cycle later. An entry write driven on a falling edge is in place after the following rising edge. The bench presents a request together with a write to show that this request still sees the old entry, and that the request after it sees the new one. Under back-pressure the bench holds `resp_ready` low for several falling edges and checks the frozen response and `req_ready` at each of them before it releases the stall.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  // access type codes carried on req_type
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // permission set, bit0 read, bit1 write, bit2 fetch
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  function automatic logic perm_allows(input perm_t p, input acc_e t);
    case (t)
      ACC_READ:  perm_allows = p.r;
      ACC_WRITE: perm_allows = p.w;
      ACC_FETCH: perm_allows = p.x;
      default:   perm_allows = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/region_slot.sv
module region_slot #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int SLOT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic [2:0]        cfg_perm,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              match,
  output logic [2:0]        perm_o
);
  logic [ADDR_W-1:0] lo_q, hi_q;
  logic [2:0]        perm_q;
  logic              en_q;
  logic              sel;

  assign sel = cfg_we && (cfg_idx == IDX_W'(SLOT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      perm_q <= '0;
      en_q   <= 1'b0;
    end else if (sel) begin
      lo_q   <= cfg_base;
      hi_q   <= cfg_limit;
      perm_q <= cfg_perm;
      en_q   <= cfg_valid;
    end
  end

  // one pair of range comparators for this entry
  assign match  = en_q && (lo_q <= look_addr) && (look_addr <= hi_q);
  assign perm_o = perm_q;

  // a cleared entry no longer hits any address
  assert_cleared_slot_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !cfg_valid) |=> !match);
endmodule

// File: rtl/lowest_first.sv
module lowest_first #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any   = 1'b1;
        idx   = IDX_W'(i);
        grant = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/region_map_guard.sv
module region_map_guard #(
  parameter int NUM_REGIONS = 5,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic [2:0]        cfg_perm,
  input  logic              cfg_valid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_type,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_hit,
  output logic [IDX_W-1:0]  resp_idx,
  output logic              resp_fault
);
  import mmap_pkg::*;

  logic [NUM_REGIONS-1:0] hits;
  logic [2:0]             slot_perm [NUM_REGIONS];
  logic                   any_hit;
  logic [IDX_W-1:0]       win_idx;
  logic [NUM_REGIONS-1:0] grant;
  logic                   allowed;
  logic                   req_fire;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
    region_slot #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOT(g)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_base  (cfg_base),
      .cfg_limit (cfg_limit),
      .cfg_perm  (cfg_perm),
      .cfg_valid (cfg_valid),
      .look_addr (req_addr),
      .match     (hits[g]),
      .perm_o    (slot_perm[g])
    );
  end

  lowest_first #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_pick (
    .req   (hits),
    .any   (any_hit),
    .idx   (win_idx),
    .grant (grant)
  );

  assign allowed   = any_hit && perm_allows(perm_t'(slot_perm[win_idx]), acc_e'(req_type));
  assign req_ready = !resp_valid || resp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_idx   <= '0;
      resp_fault <= 1'b0;
    end else if (req_ready) begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_hit   <= any_hit;
        resp_idx   <= win_idx;
        resp_fault <= !allowed;
      end
    end
  end

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_no_lower_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hits & (grant - NUM_REGIONS'(1))) == '0));

  assert_resp_after_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> resp_valid);

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_hit)
                                     && $stable(resp_idx) && $stable(resp_fault)));

  assert_miss_is_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_fault && resp_idx == '0));

  assert_reserved_type_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_type == 2'd3) |=> resp_fault);
endmodule

// File: tb/tb_region_map_guard.sv
module tb_region_map_guard;
  localparam int NR = 5;
  localparam int AW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
  logic [2:0]    cfg_perm = '0;
  logic          cfg_valid = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_type = '0;
  logic          resp_valid;
  logic          resp_ready = 1'b1;
  logic          resp_hit;
  logic [IW-1:0] resp_idx;
  logic          resp_fault;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [AW-1:0] m_lo [NR];
  logic [AW-1:0] m_hi [NR];
  logic [2:0]    m_pm [NR];
  logic          m_en [NR];
  logic [31:0]   seed = 32'h1234_5678;

  always #10 clk = ~clk;

  region_map_guard #(.NUM_REGIONS(NR), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_perm(cfg_perm),
    .cfg_valid(cfg_valid), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_type(req_type), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_hit(resp_hit), .resp_idx(resp_idx),
    .resp_fault(resp_fault)
  );

  // expected {hit, idx, fault} from the requirements
  function automatic logic [4:0] expect_of(input logic [AW-1:0] a, input logic [1:0] t);
    logic h; logic [IW-1:0] ix; logic ok;
    h = 0; ix = 0; ok = 0;
    for (int i = NR - 1; i >= 0; i--)
      if (m_en[i] && m_lo[i] <= a && a <= m_hi[i]) begin h = 1; ix = IW'(i); end
    if (h) ok = (t == 2'd3) ? 1'b0 : m_pm[ix][t];
    return {h, ix, !ok};
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a, input logic [1:0] t);
    int cnt; int first;
    cnt = 0; first = 0;
    for (int i = NR - 1; i >= 0; i--)
      if (m_en[i] && m_lo[i] <= a && a <= m_hi[i]) begin cnt++; first = i; end
    if (cnt == 0) return "R3";
    if (cnt > 1) return "R6";
    if (t == 2'd3) return "R4";
    if (m_pm[first] == 3'b100 || m_pm[first] == 3'b001) return "R5";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic write_entry(input int i, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                             input logic [2:0] pm, input logic en);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(i); cfg_base = lo; cfg_limit = hi; cfg_perm = pm; cfg_valid = en;
    @(negedge clk);
    cfg_we = 0;
    m_lo[i] = lo; m_hi[i] = hi; m_pm[i] = pm; m_en[i] = en;
  endtask

  // request on a falling edge, response one edge later (R7)
  task automatic lookup(input logic [AW-1:0] a, input logic [1:0] t, input string tag);
    logic [4:0] e;
    e = expect_of(a, t);
    req_valid = 1; req_addr = a; req_type = t;
    @(negedge clk);
    req_valid = 0;
    check("R7", {31'd0, resp_valid}, 32'd1);
    check(tag, {27'd0, resp_hit, resp_idx, resp_fault}, {27'd0, e});
  endtask

  task automatic sweep();
    @(negedge clk);
    for (int a = 0; a < (1 << AW); a++)
      for (int t = 0; t < 4; t++)
        lookup(AW'(a), 2'(t), tag_of(AW'(a), 2'(t)));
  endtask

  function automatic logic [31:0] lcg();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  initial begin
    for (int i = 0; i < NR; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_pm[i] = 0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: empty response register, ready, all entries disabled
    check("R1", {30'd0, resp_valid, req_ready}, 32'd1);
    lookup(8'h40, 2'd0, "R1");
    lookup(8'h00, 2'd2, "R1");

    // fixed layout: overlap, fetch-only, read-only, single byte, inverted bounds
    write_entry(0, 8'h10, 8'h2F, 3'b011, 1);
    write_entry(1, 8'h28, 8'h4F, 3'b100, 1);
    write_entry(2, 8'h60, 8'h7F, 3'b001, 1);
    write_entry(3, 8'h90, 8'h90, 3'b111, 1);
    write_entry(4, 8'hC0, 8'hB0, 3'b111, 1);
    sweep();
    // named corners
    lookup(8'h2F, 2'd2, "R6");
    lookup(8'h30, 2'd2, "R5");
    lookup(8'h30, 2'd0, "R5");
    lookup(8'h65, 2'd2, "R5");
    lookup(8'h8F, 2'd0, "R2");
    lookup(8'hB8, 2'd0, "R2");

    // R8: stall with resp_ready low
    @(negedge clk);
    resp_ready = 0;
    req_valid = 1; req_addr = 8'h12; req_type = 2'd1;
    @(negedge clk);
    req_addr = 8'h90; req_type = 2'd2;
    for (int k = 0; k < 3; k++) begin
      check("R8", {26'd0, resp_valid, req_ready, resp_hit, resp_idx}, {26'd0, 2'b10, 1'b1, 3'd0});
      check("R8", {31'd0, resp_fault}, 32'd0);
      @(negedge clk);
    end
    resp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R8", {27'd0, resp_hit, resp_idx, resp_fault}, {27'd0, 1'b1, 3'd3, 1'b0});
    @(negedge clk);

    // R9: request alongside a write sees the old entry, later ones the new
    cfg_we = 1; cfg_idx = 3'd2; cfg_base = 8'h60; cfg_limit = 8'h7F; cfg_perm = 3'b001; cfg_valid = 0;
    req_valid = 1; req_addr = 8'h65; req_type = 2'd0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    check("R9", {27'd0, resp_hit, resp_idx, resp_fault}, {27'd0, 1'b1, 3'd2, 1'b0});
    m_en[2] = 0;
    lookup(8'h65, 2'd0, "R9");
    check("R9", {31'd0, resp_hit}, 32'd0);

    // R2/R4 over pseudo-random layouts
    for (int c = 0; c < 3; c++) begin
      for (int i = 0; i < NR; i++) begin
        logic [31:0] r;
        r = lcg();
        write_entry(i, r[7:0], r[7:0] + {2'b00, r[13:8]}, r[18:16], r[20] | r[21]);
      end
      sweep();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule